// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves one 32-bit effective address into a physical address by searching a hashed page table in memory. The caller supplies the segment's 28-bit virtual segment identifier, the two protection key bits of that segment (one for user mode, one for supervisor mode), the current privilege mode and the table register. The table register holds the table base in its upper half and a size mask in its low nine bits. A pulse on `start` while the walker is idle captures all of these inputs. The walker then works through a primary group of page table entries and, if nothing usable is found there, through a secondary group.

Each group holds eight entries of two 32-bit words. The walker reads them one word at a time over a simple request/acknowledge memory port. When the first word of an entry equals the generated tag, it reads the second word. From that word it decodes the access rights and forms the physical address. It then sets the referenced and changed status bits as the rights allow, and stores the second word back only when one of those bits actually changes. The outcome is reported with a one-cycle `done` pulse, either together with `fault` or with the physical address and the read and write rights.

Top module: `hpt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `fault`, `mem_req`, `may_rd` and `may_wr` are all low.
- R2: `start` is accepted only while `busy` is low. A `start` pulse, or a change of the request inputs, while a walk is in progress has no effect on that walk's memory accesses or its result.
- R3: The group address is (table[31:16] << 16) OR (hash AND mask). The mask is (table[8:0] << 16) OR 0xFFC0. The primary hash is (VSID XOR ea[27:12]) << 6, and the secondary hash is the bitwise complement of the primary hash, taken before masking.
- R4: Entry i of a group has its first word at group + 8*i and its second word at group + 8*i + 4. Entries are scanned from 0 to 7, one read per word. The second word is read only after its first word matched the tag.
- R5: The tag is bit 31 set, OR (VSID << 7) truncated to 32 bits, OR 0x40 in the secondary group only, OR ea[27:22] in bits 5:0.
- R6: On a hit, the physical address is the second word with bits 11:0 replaced by ea[11:0].
- R7: The protection code is {key, word1[1:0]}. The key is the user key in user mode and the supervisor key otherwise. Codes 0, 1, 2 and 6 give read and write; codes 3, 5 and 7 give read only. Code 4 gives no access, and the scan continues with the next entry as if the tag had not matched. `may_wr` is never high without `may_rd`.
- R8: On a hit, bit 8 (referenced) is set, and bit 7 (changed) is set when writable. The updated word is written to the second-word address, and this write happens only if its value differs from the word read.
- R9: The secondary group is searched only after all eight primary entries fail. If both groups fail, `done` rises with `fault` high, `pa` is zero, and both rights are low.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_ack` is high. That cycle completes the access, and `mem_rdata` is taken in it.
- R11: `done` is high for exactly one cycle per accepted request. `pa`, `may_rd`, `may_wr` and `fault` keep their values after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a walk (taken only when idle) |
| ea | input | 32 | Effective address to translate |
| vsid | input | 28 | Virtual segment identifier of the segment |
| key_user | input | 1 | Segment protection key applied in user mode |
| key_sup | input | 1 | Segment protection key applied in supervisor mode |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| tbl | input | 32 | Table register: base in 31:16, size mask in 8:0 |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | No usable entry in either group |
| pa | output | 32 | Translated physical address |
| may_rd | output | 1 | Read access allowed |
| may_wr | output | 1 | Write access allowed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench places matching entries behind decoys whose tags differ in a single bit. A walker that compared too few tag bits would stop early, and one that compared too many would run on to a fault. The bench also places a code-4 entry ahead of a usable one and a matching entry in the secondary group while the primary also holds one. A walker that returned no-access entries, or searched the wrong group first, would issue extra or different reads. It drives words whose status bits are already set, and a design that wrote those back anyway would show an unexpected write. It uses table registers with non-zero size bits, where a wrong mask or a hash inverted after masking would fetch from the wrong group.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int unsigned VSID_W      = 28;
  localparam int unsigned ENTRY_SHIFT = 3;          // two 32-bit words per entry
  localparam logic [31:0] REF_BIT     = 32'h0000_0100;
  localparam logic [31:0] CHG_BIT     = 32'h0000_0080;

  typedef enum logic [1:0] {ST_IDLE, ST_TAG, ST_WORD1, ST_WB} walk_st_t;

  // Hash of segment id and page index; the secondary one is the complement.
  function automatic logic [31:0] hash_val(input logic [VSID_W-1:0] vsid,
                                           input logic [15:0] page,
                                           input logic sec);
    logic [31:0] h;
    h = ({4'b0, vsid} ^ {16'b0, page}) << 6;
    return sec ? ~h : h;
  endfunction

  function automatic logic [31:0] group_addr(input logic [15:0] base,
                                             input logic [8:0]  size,
                                             input logic [VSID_W-1:0] vsid,
                                             input logic [15:0] page,
                                             input logic sec);
    logic [31:0] mask;
    mask = {7'b0, size, 16'hFFC0};
    return {base, 16'h0000} | (hash_val(vsid, page, sec) & mask);
  endfunction

  function automatic logic [31:0] tag_word(input logic [VSID_W-1:0] vsid,
                                           input logic [15:0] page,
                                           input logic sec);
    logic [31:0] v;
    v = {4'b0, vsid} << 7;
    return 32'h8000_0000 | v | (sec ? 32'h0000_0040 : 32'h0) | {26'b0, page[15:10]};
  endfunction

  function automatic logic prot_read(input logic [2:0] code);
    return code != 3'd4;
  endfunction

  function automatic logic prot_write(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd6: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int unsigned GROUP_ENTRIES = 8
) (
  input  logic [15:0]       tbl_base,
  input  logic [8:0]        tbl_size,
  input  logic [VSID_W-1:0] vsid,
  input  logic [15:0]       page,
  input  logic              sec,
  input  logic [$clog2(GROUP_ENTRIES)-1:0] idx,
  output logic [31:0]       word0_addr,
  output logic [31:0]       tag
);
  logic [31:0] grp;

  assign grp        = group_addr(tbl_base, tbl_size, vsid, page, sec);
  assign word0_addr = grp + (32'(idx) << ENTRY_SHIFT);
  assign tag        = tag_word(vsid, page, sec);
endmodule

// File: rtl/hpt_perm_dec.sv
module hpt_perm_dec
  import hpt_pkg::*;
(
  input  logic        key,
  input  logic [31:0] word1,
  input  logic [11:0] ea_off,
  output logic        rd_ok,
  output logic        wr_ok,
  output logic [31:0] word1_upd,
  output logic [31:0] pa_val
);
  logic [2:0] code;

  assign code      = {key, word1[1:0]};
  assign rd_ok     = prot_read(code);
  assign wr_ok     = prot_write(code);
  assign word1_upd = word1 | (rd_ok ? REF_BIT : 32'h0) | (wr_ok ? CHG_BIT : 32'h0);
  assign pa_val    = {word1[31:12], ea_off};
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int unsigned GROUP_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic              key_user,
  input  logic              key_sup,
  input  logic              user_mode,
  input  logic [31:0]       tbl,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [31:0]       pa,
  output logic              may_rd,
  output logic              may_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int unsigned IDX_W = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  walk_st_t          st;
  logic [15:0]       page_q;
  logic [11:0]       off_q;
  logic [VSID_W-1:0] vsid_q;
  logic [15:0]       base_q;
  logic [8:0]        size_q;
  logic              key_q;
  logic              sec_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       upd_q;
  logic [31:0]       pa_q;
  logic              rd_q, wr_q, done_q, fault_q;

  logic [31:0] word0_addr, tag_v, upd_v, pa_v;
  logic        rd_ok, wr_ok;

  // named events used by the logic below and by the checker
  logic accept, xfer, tag_hit, tag_miss, entry_skip, advance, last_entry, need_wb;
  logic unused_bits;

  assign unused_bits = ^{ea[31:28], tbl[15:9]};

  hpt_addr_gen #(.GROUP_ENTRIES(GROUP_ENTRIES)) addr_i (
    .tbl_base(base_q), .tbl_size(size_q), .vsid(vsid_q), .page(page_q),
    .sec(sec_q), .idx(idx_q), .word0_addr(word0_addr), .tag(tag_v)
  );

  hpt_perm_dec perm_i (
    .key(key_q), .word1(mem_rdata), .ea_off(off_q), .rd_ok(rd_ok),
    .wr_ok(wr_ok), .word1_upd(upd_v), .pa_val(pa_v)
  );

  assign accept     = start && (st == ST_IDLE);
  assign xfer       = mem_req && mem_ack;
  assign tag_hit    = (st == ST_TAG) && xfer && (mem_rdata == tag_v);
  assign tag_miss   = (st == ST_TAG) && xfer && (mem_rdata != tag_v);
  assign entry_skip = (st == ST_WORD1) && xfer && !rd_ok;
  assign advance    = tag_miss || entry_skip;
  assign last_entry = (idx_q == LAST_IDX);
  assign need_wb    = (upd_v != mem_rdata);

  assign mem_req   = (st != ST_IDLE);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = (st == ST_TAG) ? word0_addr : word0_addr + 32'd4;
  assign mem_wdata = upd_q;

  assign busy   = (st != ST_IDLE);
  assign done   = done_q;
  assign fault  = fault_q;
  assign pa     = pa_q;
  assign may_rd = rd_q;
  assign may_wr = wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      vsid_q  <= '0;
      base_q  <= '0;
      size_q  <= '0;
      key_q   <= 1'b0;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      upd_q   <= '0;
      pa_q    <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            page_q  <= ea[27:12];
            off_q   <= ea[11:0];
            vsid_q  <= vsid;
            base_q  <= tbl[31:16];
            size_q  <= tbl[8:0];
            key_q   <= user_mode ? key_user : key_sup;
            sec_q   <= 1'b0;
            idx_q   <= '0;
            pa_q    <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            fault_q <= 1'b0;
            st      <= ST_TAG;
          end
        end
        ST_TAG: begin
          if (tag_hit) st <= ST_WORD1;
        end
        ST_WORD1: begin
          if (xfer && rd_ok) begin
            pa_q <= pa_v;
            rd_q <= 1'b1;
            wr_q <= wr_ok;
            if (need_wb) begin
              upd_q <= upd_v;
              st    <= ST_WB;
            end else begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end
        end
        ST_WB: begin
          if (xfer) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (advance) begin
        if (!last_entry) begin
          idx_q <= idx_q + IDX_W'(1);
          st    <= ST_TAG;
        end else if (!sec_q) begin
          sec_q <= 1'b1;
          idx_q <= '0;
          st    <= ST_TAG;
        end else begin
          done_q  <= 1'b1;
          fault_q <= 1'b1;
          st      <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        fault,
  input logic        may_rd,
  input logic        may_wr,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        tag_hit,
  input logic        entry_skip
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  fault_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!may_rd && !may_wr));

  // R7
  write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    may_wr |-> may_rd);

  // R8
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[8]);

  // R4
  word1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_hit |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + 32'd4)));

  // R7
  skip_moves_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_skip |=> ((mem_req && !mem_we && !mem_addr[2]) || (done && fault)));
endmodule

bind hpt_walker hpt_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .fault(fault), .may_rd(may_rd),
  .may_wr(may_wr), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tag_hit(tag_hit),
  .entry_skip(entry_skip)
);

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n, start, key_user, key_sup, user_mode;
  logic [31:0] ea, tbl;
  logic [27:0] vsid;
  logic        busy, done, fault, may_rd, may_wr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] pa, mem_addr, mem_wdata, mem_rdata;

  hpt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .vsid(vsid),
    .key_user(key_user), .key_sup(key_sup), .user_mode(user_mode), .tbl(tbl),
    .busy(busy), .done(done), .fault(fault), .pa(pa), .may_rd(may_rd),
    .may_wr(may_wr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad   = 0;
  logic [31:0] mem [int unsigned];
  logic [64:0] expq [$];          // {we, addr, data}
  int lat = 0;
  int wait_cnt = 0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // memory responder and access monitor, all activity at the falling edge
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (wait_cnt >= lat) begin
        logic [64:0] e;
        mem_ack   = 1'b1;
        mem_rdata = rdm(mem_addr);
        wait_cnt  = 0;
        if (expq.size() == 0) begin
          chk("R2/R4", "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
        end else begin
          e = expq.pop_front();
          chk("R4/R8", "access kind", {31'b0, mem_we}, {31'b0, e[64]});
          chk("R3/R4", "access address", mem_addr, e[63:32]);
          if (mem_we) begin
            chk("R8", "write data", mem_wdata, e[31:0]);
            mem[mem_addr] = mem_wdata;
          end
        end
      end else begin
        mem_ack = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  // reference arithmetic, restated independently
  function automatic logic [31:0] m_group(input logic [31:0] t, input logic [27:0] v,
                                          input logic [31:0] a, input bit sec);
    logic [31:0] page, h, mask;
    page = (a >> 12) & 32'hFFFF;
    h    = (32'(v) ^ page) * 64;
    if (sec) h = h ^ 32'hFFFF_FFFF;
    mask = ((t & 32'h1FF) * 65536) | 32'hFFC0;
    return (t & 32'hFFFF_0000) | (h & mask);
  endfunction

  function automatic logic [31:0] m_tag(input logic [27:0] v, input logic [31:0] a, input bit sec);
    return 32'h8000_0000 | (32'(v) * 128) | (sec ? 32'h40 : 32'h0) | ((a >> 22) & 32'h3F);
  endfunction

  task automatic build_expect(input logic [31:0] a_ea, input logic [31:0] a_tbl, input logic [27:0] a_v,
                              input bit ku, input bit ks, input bit um,
                              output logic [31:0] epa, output bit erd, output bit ewr, output bit eflt,
                              output bit ewb, output logic [31:0] wba, output logic [31:0] wbv);
    logic [31:0] a, w1, nw;
    int code;
    epa = 0; erd = 0; ewr = 0; eflt = 1; ewb = 0; wba = 0; wbv = 0;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        a = m_group(a_tbl, a_v, a_ea, s != 0) + 32'(i * 8);
        expq.push_back({1'b0, a, 32'h0});
        if (rdm(a) == m_tag(a_v, a_ea, s != 0)) begin
          expq.push_back({1'b0, a + 32'd4, 32'h0});
          w1   = rdm(a + 32'd4);
          code = ((um ? ku : ks) ? 4 : 0) + int'(w1 & 32'h3);
          if (code == 4) continue;
          erd  = 1;
          ewr  = (code == 0 || code == 1 || code == 2 || code == 6);
          nw   = w1 | 32'h100 | (ewr ? 32'h80 : 32'h0);
          epa  = (w1 & 32'hFFFF_F000) | (a_ea & 32'hFFF);
          eflt = 0;
          if (nw != w1) begin
            expq.push_back({1'b1, a + 32'd4, nw});
            ewb = 1; wba = a + 32'd4; wbv = nw;
          end
          return;
        end
      end
    end
  endtask

  task automatic put(input logic [31:0] t, input logic [27:0] v, input logic [31:0] a,
                     input bit sec, input int slot, input logic [31:0] tag_flip, input logic [31:0] w1);
    logic [31:0] b;
    b = m_group(t, v, a, sec) + 32'(slot * 8);
    mem[b]          = m_tag(v, a, sec) ^ tag_flip;
    mem[b + 32'd4]  = w1;
  endtask

  task automatic xlate(input string rq, input logic [31:0] a_ea, input logic [31:0] a_tbl,
                       input logic [27:0] a_v, input bit ku, input bit ks, input bit um,
                       input int lat_i, input bit poke);
    logic [31:0] epa, wba, wbv;
    bit erd, ewr, eflt, ewb;
    int n;
    build_expect(a_ea, a_tbl, a_v, ku, ks, um, epa, erd, ewr, eflt, ewb, wba, wbv);
    lat = lat_i;
    @(negedge clk);
    ea = a_ea; tbl = a_tbl; vsid = a_v; key_user = ku; key_sup = ks; user_mode = um;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk("R2", "busy during walk", {31'b0, busy}, 32'd1);
      ea = a_ea ^ 32'h0ABC_D000; vsid = ~a_v; user_mode = ~um; tbl = a_tbl ^ 32'h0100_0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) chk("R11", "done timeout", 32'd0, 32'd1);
    chk(rq, "fault", {31'b0, fault}, {31'b0, eflt});
    chk(rq, "pa", pa, epa);
    chk(rq, "may_rd", {31'b0, may_rd}, {31'b0, erd});
    chk(rq, "may_wr", {31'b0, may_wr}, {31'b0, ewr});
    chk("R4", "accesses left over", 32'(expq.size()), 32'd0);
    if (ewb) chk("R8", "stored status word", rdm(wba), wbv);
    expq.delete();
    @(negedge clk);
    chk("R11", "done after pulse", {31'b0, done}, 32'd0);
    chk("R11", "pa held", pa, epa);
    chk("R11", "fault held", {31'b0, fault}, {31'b0, eflt});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] tA, tB, eA;
    logic [27:0] vA;
    rst_n = 1'b0; start = 1'b0; ea = '0; tbl = '0; vsid = '0;
    key_user = 1'b0; key_sup = 1'b0; user_mode = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {26'b0, busy, done, fault, mem_req, may_rd, may_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {26'b0, busy, done, fault, mem_req, may_rd, may_wr}, 32'd0);

    tA = 32'h0012_0000; vA = 28'h0AB_CDEF; eA = 32'h1234_5678;

    // primary slot 0, code 2, status bits clear -> write back
    mem.delete();
    put(tA, vA, eA, 0, 0, 32'h0, 32'h0055_5002);
    xlate("R6", eA, tA, vA, 0, 0, 0, 0, 0);

    // decoys with single-bit tag differences, hit at slot 5, bits already set
    mem.delete();
    for (int i = 0; i < 5; i++) put(tA, vA, eA, 0, i, 32'h1 << (i * 7), 32'h0099_9002);
    put(tA, vA, eA, 0, 5, 32'h0, 32'h0077_7182);
    put(tA, vA, eA, 1, 0, 32'h0, 32'h0066_6002);
    xlate("R5", eA, tA, vA, 0, 0, 0, 2, 0);

    // supervisor key, code 5: read only, referenced bit set
    mem.delete();
    put(tA, vA, eA, 0, 2, 32'h0, 32'h0011_1001);
    xlate("R7", eA, tA, vA, 0, 1, 0, 1, 0);

    // user key, code 4 entry skipped, later code 6 entry used
    mem.delete();
    put(tA, vA, eA, 0, 1, 32'h0, 32'h0022_2000);
    put(tA, vA, eA, 0, 3, 32'h0, 32'h0033_3002);
    xlate("R7", eA, tA, vA, 1, 0, 1, 1, 0);

    // code 3 with referenced already set: no write
    mem.delete();
    put(tA, vA, eA, 0, 6, 32'h0, 32'h0044_4103);
    xlate("R8", eA, tA, vA, 0, 1, 1, 3, 0);

    // primary empty, secondary slot 7
    mem.delete();
    put(tA, vA, eA, 1, 7, 32'h0, 32'h0088_8001);
    xlate("R9", eA, tA, vA, 0, 0, 0, 1, 0);

    // only a no-access match in the primary: fault
    mem.delete();
    put(tA, vA, eA, 0, 2, 32'h0, 32'h0055_5000);
    put(tA, vA, eA, 1, 3, 32'h40, 32'h0055_5002);
    xlate("R9", eA, tA, vA, 0, 1, 0, 0, 0);

    // start and input changes while busy are ignored
    mem.delete();
    put(tA, vA, eA, 0, 0, 32'h0, 32'h0055_5002);
    xlate("R2", eA, tA, vA, 0, 0, 0, 2, 1);

    // size mask bits in use, primary and secondary
    tB = 32'h0100_01FF;
    mem.delete();
    put(tB, 28'hFED_CBA9, 32'hF00D_BEEF, 0, 4, 32'h0, 32'h1234_5000);
    xlate("R3", 32'hF00D_BEEF, tB, 28'hFED_CBA9, 0, 0, 0, 1, 0);
    mem.delete();
    put(tB, 28'h00F_0F0F, 32'h0FFF_F123, 1, 1, 32'h0, 32'hABCD_E002);
    xlate("R3", 32'h0FFF_F123, tB, 28'h00F_0F0F, 1, 1, 1, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule